// File: doc/BRIEF.md
# Frame-Synchronous Channel Buffer Status Unit

This block sits between a processor's register strobes and a time-division serial framer. For each of four ports it double-buffers three channels: two 8-bit bearer channels (B1, B2) and one 2-bit signalling channel (D). Each channel has a transmit path and a receive path. The processor writes transmit data registers and reads receive data registers. The framer sees the transmit shadow registers on `tx_out` and fills the receive shadow registers through `rx_in` and `rx_load`.

On every super-frame tick (`sf_tick`, nominally 2 kHz) the unit does two things for every channel at once. It copies the transmit data register into the transmit shadow register. It also moves the receive shadow register into the receive data register. Each port keeps a 16-bit status word. The word holds per-channel transmit-empty and receive-full flags, and underrun and overrun error flags. The error flags are set when a tick finds a buffer that has not been serviced. Reading the status word clears that port's error flags.

Top module: `chbuf_status_unit`

## Requirements
- R1: After reset every status word reads 0x0000, `tx_out` is all zeros and every data register reads zero.
- R2: Status word layout: bits 15:12 read zero. Bits 11/10/9 are D/B2/B1 transmit underrun. Bits 8/7/6 are D/B2/B1 receive overrun. Bits 5/4/3 are D/B2/B1 transmit empty. Bits 2/1/0 are D/B2/B1 receive full.
- R3: On a tick, each transmit data register is copied to its shadow and appears on `tx_out` after that clock edge. Per port p the bus slice is p*18 wide: B1 at bits [7:0], B2 at [15:8], D at [17:16]. The tick also sets the channel's transmit-empty flag.
- R4: A tick that finds a channel's transmit-empty flag already set sets that channel's transmit underrun flag.
- R5: A CPU write to a transmit data register clears that channel's transmit-empty flag. If the write lands in the same cycle as a tick, the shadow takes the old data, the register takes the new data, and empty ends cleared.
- R6: `rx_load` captures `rx_in` (same slice layout as R3) into the receive shadows. A tick moves each receive shadow into its receive data register and sets receive-full. A CPU read of that receive data register clears receive-full.
- R7: A tick that finds receive-full set sets the receive overrun flag. The exception is a tick that coincides with a CPU read of that receive data register: it sets no overrun, and full stays set.
- R8: A CPU read of a port's status word returns the pre-read value. It then clears that port's six error flags and leaves its empty/full flags and the other ports untouched.
- R9: An error event in the same cycle as a status read of that port leaves the new error flag set.
- R10: D-channel data registers are 2 bits wide. Write bits above bit 1 are ignored, and reads return zero above bit 1.
- R11: The four ports are independent. The address is {port[1:0], code[2:0]}. Code 0 is status, codes 1/2/3 are B1/B2/D transmit data, and codes 5/6/7 are B1/B2/D receive data.
- R12: Code 4 reads as zero, and a write to it changes no register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sf_tick | input | 1 | Super-frame transfer strobe, one cycle |
| rx_load | input | 1 | Framer strobe loading `rx_in` into receive shadows |
| rx_in | input | 72 | Receive shadow load data, 18 bits per port |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 5 | {port, register code} |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 16 | Read data, combinational from address and state |
| tx_out | output | 72 | Transmit shadow registers toward the framer, 18 bits per port |

## Verification
Read data is combinational, so `cpu_rdata` is compared in the same cycle as the `cpu_rd` strobe. It is sampled shortly after the inputs are driven and before the clock edge, and it reflects the state before any clear that the read causes. Every side effect of a tick, a write or a read lands at the next rising edge. The bench therefore updates its reference model at that edge. It compares `tx_out` at the following falling edge, and it observes flags through a status read issued one cycle later. Coincident events (tick with write, tick with data read, tick with status read) are driven in a single cycle, and their results are checked one cycle after that.

// File: rtl/chbuf_pkg.sv
// Shared constants and helpers for the channel buffer status unit.
// Assumes three channels per port with D as the highest index.
package chbuf_pkg;
    localparam int NCH   = 3;
    localparam int CH_B1 = 0;
    localparam int CH_B2 = 1;
    localparam int CH_D  = 2;

    typedef enum logic [2:0] {
        RC_STAT  = 3'd0,
        RC_TX_B1 = 3'd1,
        RC_TX_B2 = 3'd2,
        RC_TX_D  = 3'd3,
        RC_NONE  = 3'd4,
        RC_RX_B1 = 3'd5,
        RC_RX_B2 = 3'd6,
        RC_RX_D  = 3'd7
    } reg_code_e;

    // One-hot channel select for a transmit data register code.
    function automatic logic [NCH-1:0] tx_sel(input logic [2:0] code);
        case (code)
            RC_TX_B1: return 3'b001;
            RC_TX_B2: return 3'b010;
            RC_TX_D:  return 3'b100;
            default:  return 3'b000;
        endcase
    endfunction

    // One-hot channel select for a receive data register code.
    function automatic logic [NCH-1:0] rx_sel(input logic [2:0] code);
        case (code)
            RC_RX_B1: return 3'b001;
            RC_RX_B2: return 3'b010;
            RC_RX_D:  return 3'b100;
            default:  return 3'b000;
        endcase
    endfunction
endpackage

// File: rtl/chbuf_tx_lane.sv
// Transmit lane: CPU-written data register, shadow register, empty and
// underrun flags for one channel. Assumes tick and wr are single-cycle strobes.
module chbuf_tx_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         err_clr,
    output logic [W-1:0] data_q,
    output logic [W-1:0] shadow,
    output logic         empty,
    output logic         underrun
);
    // Data register, shadow copy on tick, flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            shadow   <= '0;
            empty    <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (tick) shadow <= data_q;
            if (wr)   data_q <= wdata;
            if (wr)        empty <= 1'b0;
            else if (tick) empty <= 1'b1;
            underrun <= (tick && empty) || (underrun && !err_clr);
        end
    end

    a_r3_shadow_copy: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> shadow == $past(data_q));
    a_r3_tick_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr) |=> empty);
    a_r5_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !empty);
    a_r4_r9_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && empty) |=> underrun);
    a_r8_underrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(tick && empty)) |=> !underrun);
endmodule

// File: rtl/chbuf_rx_lane.sv
// Receive lane: framer-loaded shadow, CPU-read data register, full and
// overrun flags for one channel. Assumes rd marks a CPU read of data_q.
module chbuf_rx_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] rx_in,
    input  logic         tick,
    input  logic         rd,
    input  logic         err_clr,
    output logic [W-1:0] data_q,
    output logic         full,
    output logic         overrun
);
    logic [W-1:0] shadow;

    // Shadow load, transfer on tick, flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow  <= '0;
            data_q  <= '0;
            full    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (load) shadow <= rx_in;
            if (tick) data_q <= shadow;
            if (tick)    full <= 1'b1;
            else if (rd) full <= 1'b0;
            overrun <= (tick && full && !rd) || (overrun && !err_clr);
        end
    end

    a_r6_tick_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> full);
    a_r6_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !tick) |=> !full);
    a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && full && !rd) |=> overrun);
    a_r8_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(tick && full && !rd)) |=> !overrun);
endmodule

// File: rtl/chbuf_port.sv
// One port: three transmit and three receive lanes plus the status word.
// Assumes select vectors are one-hot or zero; D lane is DW bits, B lanes BW.
module chbuf_port
    import chbuf_pkg::*;
#(
    parameter int BW = 8,
    parameter int DW = 2,
    localparam int PW = 2*BW + DW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    load,
    input  logic [PW-1:0]           rx_in,
    input  logic [NCH-1:0]          wr_sel,
    input  logic [NCH-1:0]          rd_sel,
    input  logic                    stat_rd,
    input  logic [BW-1:0]           wdata,
    output logic [PW-1:0]           tx_out,
    output logic [NCH-1:0][BW-1:0]  tx_q,
    output logic [NCH-1:0][BW-1:0]  rx_q,
    output logic [15:0]             status
);
    logic [NCH-1:0] emp, und, full, ovr;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int W   = (c == CH_D) ? DW : BW;
        localparam int OFF = c * BW;

        chbuf_tx_lane #(.W(W)) u_tx (
            .clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr_sel[c]),
            .wdata(wdata[W-1:0]), .err_clr(stat_rd),
            .data_q(tx_q[c][W-1:0]), .shadow(tx_out[OFF +: W]),
            .empty(emp[c]), .underrun(und[c])
        );

        chbuf_rx_lane #(.W(W)) u_rx (
            .clk(clk), .rst_n(rst_n), .load(load), .rx_in(rx_in[OFF +: W]),
            .tick(tick), .rd(rd_sel[c]), .err_clr(stat_rd),
            .data_q(rx_q[c][W-1:0]), .full(full[c]), .overrun(ovr[c])
        );

        if (W < BW) begin : g_pad
            assign tx_q[c][BW-1:W] = '0;
            assign rx_q[c][BW-1:W] = '0;
        end
    end

    // Status word: errors above buffer-state flags, D at the top of each group.
    assign status = {4'b0000, und, ovr, emp, full};
endmodule

// File: rtl/chbuf_status_unit.sv
// Top: decodes CPU strobes to NPORT ports and muxes combinational read data.
// Assumes cpu_rd and cpu_wr are not asserted together; side effects at next edge.
module chbuf_status_unit
    import chbuf_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int BW    = 8,
    parameter int DW    = 2,
    localparam int PW   = 2*BW + DW,
    localparam int PAW  = $clog2(NPORT),
    localparam int AW   = PAW + 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sf_tick,
    input  logic                rx_load,
    input  logic [NPORT*PW-1:0] rx_in,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    input  logic [AW-1:0]       cpu_addr,
    input  logic [BW-1:0]       cpu_wdata,
    output logic [15:0]         cpu_rdata,
    output logic [NPORT*PW-1:0] tx_out
);
    logic [PAW-1:0] a_port;
    logic [2:0]     a_code;
    logic [NPORT-1:0][15:0]           stat_w;
    logic [NPORT-1:0][NCH-1:0][BW-1:0] txq_w, rxq_w;

    assign a_port = cpu_addr[AW-1:3];
    assign a_code = cpu_addr[2:0];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic hit;
        assign hit = (a_port == PAW'(p));

        chbuf_port #(.BW(BW), .DW(DW)) u_port (
            .clk(clk), .rst_n(rst_n), .tick(sf_tick), .load(rx_load),
            .rx_in(rx_in[p*PW +: PW]),
            .wr_sel((cpu_wr && hit) ? tx_sel(a_code) : 3'b000),
            .rd_sel((cpu_rd && hit) ? rx_sel(a_code) : 3'b000),
            .stat_rd(cpu_rd && hit && (a_code == RC_STAT)),
            .wdata(cpu_wdata),
            .tx_out(tx_out[p*PW +: PW]),
            .tx_q(txq_w[p]), .rx_q(rxq_w[p]), .status(stat_w[p])
        );
    end

    // Read mux: status, transmit readback, receive data; code 4 and idle give zero.
    always_comb begin
        cpu_rdata = '0;
        if (cpu_rd) begin
            case (a_code)
                RC_STAT:  cpu_rdata = stat_w[a_port];
                RC_TX_B1: cpu_rdata = 16'(txq_w[a_port][CH_B1]);
                RC_TX_B2: cpu_rdata = 16'(txq_w[a_port][CH_B2]);
                RC_TX_D:  cpu_rdata = 16'(txq_w[a_port][CH_D]);
                RC_RX_B1: cpu_rdata = 16'(rxq_w[a_port][CH_B1]);
                RC_RX_B2: cpu_rdata = 16'(rxq_w[a_port][CH_B2]);
                RC_RX_D:  cpu_rdata = 16'(rxq_w[a_port][CH_D]);
                default:  cpu_rdata = '0;
            endcase
        end
    end

    a_r1_reset_clears_output: assert property (@(posedge clk)
        !rst_n |=> tx_out == '0);
    a_r2_reserved_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && a_code == RC_STAT) |-> cpu_rdata[15:12] == 4'b0000);
endmodule

// File: tb/test_chbuf_status_unit.sv
// Bench: directed corner cases then seeded random traffic against a reference model.
module test_chbuf_status_unit;
    localparam int NP = 4, BW = 8, PW = 18;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sf_tick = 0, rx_load = 0, cpu_rd = 0, cpu_wr = 0;
    logic [NP*PW-1:0] rx_in = '0;
    logic [4:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic [NP*PW-1:0] tx_out;

    int n_chk = 0, n_fail = 0;

    chbuf_status_unit i_chbuf_status_unit (
        .clk(clk), .rst_n(rst_n), .sf_tick(sf_tick), .rx_load(rx_load), .rx_in(rx_in),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .tx_out(tx_out)
    );

    always #5 clk = ~clk;

    // Reference model state, index [port][channel], channel 2 = D
    logic [7:0] m_tx[NP][3], m_sh[NP][3], m_rs[NP][3], m_rx[NP][3];
    logic m_emp[NP][3], m_und[NP][3], m_full[NP][3], m_ovr[NP][3];

    function automatic logic [7:0] cmask(int c);
        return (c == 2) ? 8'h03 : 8'hFF;
    endfunction

    function automatic logic [15:0] m_status(int p);
        logic [15:0] s = '0;
        for (int c = 0; c < 3; c++) begin
            s[9+c] = m_und[p][c]; s[6+c] = m_ovr[p][c];
            s[3+c] = m_emp[p][c]; s[c]   = m_full[p][c];
        end
        return s;
    endfunction

    function automatic logic [15:0] m_read(logic [4:0] a);
        int p = int'(a[4:3]);
        int r = int'(a[2:0]);
        if (r == 0) return m_status(p);
        if (r >= 1 && r <= 3) return {8'h00, m_tx[p][r-1]};
        if (r >= 5) return {8'h00, m_rx[p][r-5]};
        return 16'h0000;
    endfunction

    function automatic logic [NP*PW-1:0] m_txout();
        logic [NP*PW-1:0] v = '0;
        for (int p = 0; p < NP; p++) begin
            v[p*PW +: 8] = m_sh[p][0];
            v[p*PW+8 +: 8] = m_sh[p][1];
            v[p*PW+16 +: 2] = m_sh[p][2][1:0];
        end
        return v;
    endfunction

    task automatic chk(string tag, logic [NP*PW-1:0] act, logic [NP*PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < 3; c++) begin
                m_tx[p][c] = 0; m_sh[p][c] = 0; m_rs[p][c] = 0; m_rx[p][c] = 0;
                m_emp[p][c] = 0; m_und[p][c] = 0; m_full[p][c] = 0; m_ovr[p][c] = 0;
            end
    endtask

    // One cycle: drive, check read data before the edge, update model at the edge,
    // check tx_out at the next falling edge. op: 0 idle, 1 read, 2 write.
    task automatic step(string tag, bit tk, bit ld, logic [NP*PW-1:0] rin,
                        int op, logic [4:0] a, logic [7:0] wd);
        int p = int'(a[4:3]);
        int r = int'(a[2:0]);
        @(negedge clk);
        sf_tick = tk; rx_load = ld; rx_in = rin;
        cpu_rd = (op == 1); cpu_wr = (op == 2); cpu_addr = a; cpu_wdata = wd;
        #1;
        if (op == 1) chk(tag, 72'(cpu_rdata), 72'(m_read(a)));
        @(posedge clk);
        for (int q = 0; q < NP; q++)
            for (int c = 0; c < 3; c++) begin
                bit wr_h = (op == 2) && q == p && r == c + 1;
                bit rd_h = (op == 1) && q == p && r == c + 5;
                bit clr  = (op == 1) && q == p && r == 0;
                bit e0 = m_emp[q][c], f0 = m_full[q][c];
                if (tk) m_sh[q][c] = m_tx[q][c];
                if (wr_h) m_tx[q][c] = wd & cmask(c);
                m_emp[q][c] = wr_h ? 1'b0 : (tk ? 1'b1 : e0);
                m_und[q][c] = (tk && e0) || (m_und[q][c] && !clr);
                if (tk) m_rx[q][c] = m_rs[q][c];
                m_full[q][c] = tk ? 1'b1 : (rd_h ? 1'b0 : f0);
                m_ovr[q][c] = (tk && f0 && !rd_h) || (m_ovr[q][c] && !clr);
                if (ld) m_rs[q][c] = rin[q*PW + c*8 +: 8] & cmask(c);
            end
        @(negedge clk);
        chk("R3 tx_out", tx_out, m_txout());
        sf_tick = 0; rx_load = 0; cpu_rd = 0; cpu_wr = 0;
    endtask

    function automatic logic [4:0] ad(int p, int r);
        return 5'((p << 3) | r);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [NP*PW-1:0] pat;
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset state, with literal expectations
        for (int p = 0; p < NP; p++) step("R1 status", 0, 0, '0, 1, ad(p, 0), 0);
        step("R1 rx data", 0, 0, '0, 1, ad(1, 5), 0);
        chk("R1 tx_out literal", tx_out, '0);
        // R10: D register width
        step("R10 write", 0, 0, '0, 2, ad(0, 3), 8'hFF);
        step("R10 readback", 0, 0, '0, 1, ad(0, 3), 0);
        chk("R10 literal", 72'(cpu_rdata), 72'h3);
        step("R5 write B1", 0, 0, '0, 2, ad(0, 1), 8'hA5);
        // R3/R4: tick copies, sets empty; second tick underruns
        step("R3 tick", 1, 0, '0, 0, 0, 0);
        chk("R3 B1 literal", 72'(tx_out[7:0]), 72'hA5);
        step("R3 status empty", 0, 0, '0, 1, ad(0, 0), 0);
        step("R4 tick", 1, 0, '0, 0, 0, 0);
        step("R4 underrun", 0, 0, '0, 1, ad(0, 0), 0);
        // R8: status read cleared errors; empty remains; R11 other port clean
        step("R8 after clear", 0, 0, '0, 1, ad(0, 0), 0);
        step("R11 port1", 0, 0, '0, 1, ad(1, 0), 0);
        // R5: write coincident with tick
        step("R5 write+tick", 1, 0, '0, 2, ad(2, 2), 8'h3C);
        step("R5 status", 0, 0, '0, 1, ad(2, 0), 0);
        // R6/R12: receive path
        pat = '0;
        for (int i = 0; i < NP*PW; i++) pat[i] = (i % 3) == 0;
        step("R12 load", 0, 1, pat, 0, 0, 0);
        step("R6 tick", 1, 0, '0, 0, 0, 0);
        step("R6 full", 0, 0, '0, 1, ad(3, 0), 0);
        step("R6 rx B2", 0, 0, '0, 1, ad(3, 6), 0);
        step("R6 rx D", 0, 0, '0, 1, ad(3, 7), 0);
        step("R6 cleared", 0, 0, '0, 1, ad(3, 0), 0);
        // R7: tick with full set overruns except on the read channel
        step("R7 tick", 1, 0, '0, 1, ad(3, 5), 0);
        step("R7 status", 0, 0, '0, 1, ad(3, 0), 0);
        // R9: error event during status read survives
        step("R9 tick+read", 1, 0, '0, 1, ad(3, 0), 0);
        step("R9 kept", 0, 0, '0, 1, ad(3, 0), 0);
        // R12: code 4 reads zero, write has no effect
        step("R12 write", 0, 0, '0, 2, ad(1, 4), 8'h77);
        step("R12 read", 0, 0, '0, 1, ad(1, 4), 0);
        step("R12 status", 0, 0, '0, 1, ad(1, 0), 0);
        // Random traffic, checked against the model (R2-R12)
        for (int i = 0; i < 4000; i++) begin
            int op = int'($urandom_range(2, 0));
            step("R11 random", ($urandom_range(7, 0) == 0), ($urandom_range(3, 0) == 0),
                 {$urandom(), $urandom(), $urandom()}, op,
                 5'($urandom_range(31, 0)), 8'($urandom()));
        end
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule